// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block answers a processor's interrupt-acknowledge cycle with an 8-bit vector. The upper nibble of the vector comes from a base register that software writes through a simple byte-wide register port. The lower nibble is a code for the most urgent of fourteen level-sensitive request lines.

Three of the request lines belong to a serial controller. For each of them a per-source enable picks how its vector is formed. When the enable is set, the block builds the vector from the base and a code, as it does for any other source. When the enable is clear, the vector that the serial controller presents is passed through untouched.

The winner and its vector are captured once, in the first cycle of an acknowledge. They are held unchanged until the acknowledge ends. Software normally writes 0x50 to the base, which places the vectors at 0x50 to 0x5D.

Top module: `irq_vector_gen`

## Requirements
- R1: After reset, and until the first write, `reg_rdata` reads 0x0F.
- R2: After any write (`reg_wr` high at a clock edge), `reg_rdata` reads `{written bits 7..4, 4'b0000}`. The written bits 3..0 are ignored. The register stays in this written state until the next reset.
- R3: Request bit `req[i]` has code `i` (0x0 to 0xD). The active request with the largest index wins.
- R4: For a winning request with index 0 to 10, the vector is `{base bits 7..4, code}`.
- R5: Requests 11, 12 and 13 are the serial sources, and `ser_auto_en[i-11]` is the enable for request `i`. When that enable is 1, the vector is `{base, code}`. When it is 0, the vector is `ser_vec` unchanged. A serial source competes for priority whatever its enable value.
- R6: An acknowledge starts in the first cycle in which `ack_req` is sampled high after being sampled low. From the next cycle, and for as long as `ack_req` stays high, `vec_out` shows the vector that was captured at the start. It does not change when the requests, the enables, `ser_vec` or the base change during the acknowledge.
- R7: If no request is active when an acknowledge starts, `spurious` is high for that acknowledge, `vec_valid` is low and `vec_out` is 0x00. Otherwise `vec_valid` is high and `spurious` is low.
- R8: One cycle after `ack_req` is sampled low, `vec_valid` and `spurious` are low and `vec_out` is 0x00.
- R9: `vec_valid` and `spurious` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the base register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the base register |
| req | input | 14 | Level-sensitive request lines, bit index = code |
| ser_auto_en | input | 3 | Enables for the serial sources 11..13 (1 = form vector from base and code) |
| ser_vec | input | 8 | Vector supplied by the serial controller |
| ack_req | input | 1 | Acknowledge cycle in progress |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | `vec_out` is valid for this acknowledge |
| spurious | output | 1 | Acknowledge with no active request |

## Verification
The assertions check on every cycle that `vec_valid` and `spurious` are never high together. They check that both outputs are quiet whenever the previous cycle had no acknowledge, and that the vector holds steady through an acknowledge. They also check that a read right after a write shows the written upper nibble over zeros, and that the low nibble of a read is always 0x0 or 0xF.

The bench's scenarios cover the behaviour that needs a reference model:
- which request wins for a given set of requests;
- the per-enable choice between a base-plus-code vector and the serial controller's vector;
- the 0x0F read that comes back after a second reset;
- the vector being frozen while the requests change in the middle of an acknowledge.

// File: rtl/irq_vec_pkg.sv
// Package: shared widths for the interrupt vector generator.
// Assumes an 8-bit vector split into a base nibble and a code nibble.
package irq_vec_pkg;
    localparam int VEC_W  = 8;
    localparam int CODE_W = 4;
    localparam int BASE_W = VEC_W - CODE_W;
    localparam logic [CODE_W-1:0] UNINIT_LOW = '1;
endpackage

// File: rtl/irq_prio_enc.sv
// Module: irq_prio_enc
// Finds the highest-index active request and returns its index as the code.
// Assumes NUM_SRC <= 2**CODE_W. Purely combinational.
module irq_prio_enc
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 14
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               hit,
    output logic [CODE_W-1:0]  code
);
    // Scan upward so that the last active index found is the winner.
    always_comb begin
        hit  = 1'b0;
        code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                hit  = 1'b1;
                code = CODE_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_base_reg.sv
// Module: irq_base_reg
// Holds the writable base nibble and a one-flop "written" flag.
// Before the first write, the low read bits show all ones; after it, zeros.
// Assumes a synchronous active-low reset.
module irq_base_reg
    import irq_vec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [VEC_W-1:0]  wdata,
    output logic [BASE_W-1:0] base,
    output logic [VEC_W-1:0]  rdata
);
    logic written_q;

    // Store the upper nibble and mark the register as initialized.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base      <= '0;
            written_q <= 1'b0;
        end else if (wr) begin
            base      <= wdata[VEC_W-1:CODE_W];
            written_q <= 1'b1;
        end
    end

    // Build the read value from the stored nibble and the flag.
    always_comb rdata = {base, written_q ? {CODE_W{1'b0}} : UNINIT_LOW};
endmodule

// File: rtl/irq_ack_ctrl.sv
// Module: irq_ack_ctrl
// Detects the start of an acknowledge, captures the vector or a spurious
// result, and presents it until the acknowledge ends.
// Assumes ack_req stays high for the whole acknowledge.
module irq_ack_ctrl
    import irq_vec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic             hit,
    input  logic [VEC_W-1:0] vec_next,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_valid,
    output logic             spurious
);
    logic             ack_d;
    logic             active_q;
    logic             hit_q;
    logic [VEC_W-1:0] vec_q;
    logic             start;

    // Start of an acknowledge: high now, low in the previous cycle.
    always_comb start = ack_req && !ack_d;

    // Track the acknowledge and capture the result at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d    <= 1'b0;
            active_q <= 1'b0;
            hit_q    <= 1'b0;
            vec_q    <= '0;
        end else begin
            ack_d <= ack_req;
            if (!ack_req) begin
                active_q <= 1'b0;
            end else if (start) begin
                active_q <= 1'b1;
                hit_q    <= hit;
                vec_q    <= hit ? vec_next : '0;
            end
        end
    end

    // Drive the outputs only while an acknowledge is in progress.
    always_comb begin
        vec_valid = active_q && hit_q;
        spurious  = active_q && !hit_q;
        vec_out   = vec_valid ? vec_q : '0;
    end
endmodule

// File: rtl/irq_vector_gen.sv
// Module: irq_vector_gen (top)
// Returns a prioritized interrupt vector from a programmable base during an
// acknowledge. The top NUM_SER sources may instead pass through an external
// vector when their auto-vector enable is clear.
// Assumes NUM_SER <= NUM_SRC <= 16.
module irq_vector_gen
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int NUM_SER = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [VEC_W-1:0]   reg_wdata,
    output logic [VEC_W-1:0]   reg_rdata,
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SER-1:0] ser_auto_en,
    input  logic [VEC_W-1:0]   ser_vec,
    input  logic               ack_req,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_valid,
    output logic               spurious
);
    localparam int SER_FIRST = NUM_SRC - NUM_SER;

    logic [BASE_W-1:0] base;
    logic              hit;
    logic [CODE_W-1:0] code;
    logic              pass_ext;
    logic [VEC_W-1:0]  vec_next;

    irq_base_reg u_base (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .base  (base),
        .rdata (reg_rdata)
    );

    irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
        .req  (req),
        .hit  (hit),
        .code (code)
    );

    // Decide whether the winner is a serial source without auto-vectoring.
    always_comb begin
        pass_ext = 1'b0;
        for (int j = 0; j < NUM_SER; j++) begin
            if (code == CODE_W'(SER_FIRST + j) && !ser_auto_en[j]) begin
                pass_ext = 1'b1;
            end
        end
    end

    // Form the candidate vector for the current winner.
    always_comb vec_next = pass_ext ? ser_vec : {base, code};

    irq_ack_ctrl u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_req   (ack_req),
        .hit       (hit),
        .vec_next  (vec_next),
        .vec_out   (vec_out),
        .vec_valid (vec_valid),
        .spurious  (spurious)
    );
endmodule

// File: rtl/irq_vector_gen_chk.sv
// Module: irq_vector_gen_chk
// Port-level checks on the vector generator, attached with bind.
module irq_vector_gen_chk
    import irq_vec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [VEC_W-1:0] reg_wdata,
    input logic [VEC_W-1:0] reg_rdata,
    input logic             ack_req,
    input logic [VEC_W-1:0] vec_out,
    input logic             vec_valid,
    input logic             spurious
);
    AST_VALID_SPUR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && spurious)); // R9

    AST_QUIET_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_req) |-> (!vec_valid && !spurious && vec_out == '0)); // R8

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(vec_valid) && $past(ack_req) && ack_req) |-> $stable(vec_out)); // R6

    AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_wr)) |-> reg_rdata == {$past(reg_wdata[VEC_W-1:CODE_W]), {CODE_W{1'b0}}}); // R2

    AST_RD_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[CODE_W-1:0] == '0 || reg_rdata[CODE_W-1:0] == '1)); // R1
endmodule

bind irq_vector_gen irq_vector_gen_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ack_req   (ack_req),
    .vec_out   (vec_out),
    .vec_valid (vec_valid),
    .spurious  (spurious)
);

// File: tb/test_irq_vector_gen.sv
module test_irq_vector_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [13:0] req;
    logic [2:0]  ser_auto_en;
    logic [7:0]  ser_vec;
    logic        ack_req;
    logic [7:0]  vec_out;
    logic        vec_valid;
    logic        spurious;

    int checks = 0;
    int errors = 0;
    logic [3:0] base_m;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    irq_vector_gen i_irq_vector_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req(req), .ser_auto_en(ser_auto_en),
        .ser_vec(ser_vec), .ack_req(ack_req), .vec_out(vec_out),
        .vec_valid(vec_valid), .spurious(spurious)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Reference model: vector for a request set (R3, R4, R5).
    function automatic logic [7:0] exp_vec(input logic [13:0] r, input logic [2:0] a,
                                           input logic [7:0] sv, input logic [3:0] b);
        int w = -1;
        for (int i = 0; i < 14; i++) if (r[i]) w = i;
        if (w < 0) return 8'h00;
        if (w >= 11 && !a[w-11]) return sv;
        return {b, 4'(w)};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 0; reg_wdata = 0; req = 0;
        ser_auto_en = 3'b111; ser_vec = 0; ack_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; base_m = 4'h0;
        @(negedge clk);
    endtask

    task automatic write_base(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        base_m = d[7:4];
        check("R2 read after write", {8'h0, reg_rdata}, {8'h0, d[7:4], 4'h0});
    endtask

    task automatic run_ack(input logic [13:0] r, input logic [2:0] a, input logic [7:0] sv,
                           input string tag);
        logic [7:0] e;
        logic       h;
        req = r; ser_auto_en = a; ser_vec = sv; ack_req = 1'b1;
        e = exp_vec(r, a, sv, base_m);
        h = (r != 0);
        @(negedge clk);
        check({tag, " vector"}, {8'h0, vec_out}, {8'h0, e});
        check("R7 valid/spurious", {14'h0, vec_valid, spurious}, {14'h0, h, !h});
        // Change every input mid-acknowledge; the vector must hold (R6).
        req = ~r; ser_auto_en = ~a; ser_vec = ~sv;
        @(negedge clk);
        check("R6 held vector", {8'h0, vec_out}, {8'h0, e});
        ack_req = 1'b0;
        @(negedge clk);
        check("R8 quiet after ack", {7'h0, vec_valid, spurious, vec_out}, 16'h0);
        req = 0;
    endtask

    initial begin
        do_reset();
        check("R1 reset read", {8'h0, reg_rdata}, 16'h000F);
        check("R8 quiet after reset", {7'h0, vec_valid, spurious, vec_out}, 16'h0);
        run_ack(14'h0, 3'b111, 8'h00, "R7 spurious");
        write_base(8'h57);
        for (int i = 0; i < 14; i++) run_ack(14'(1) << i, 3'b111, 8'hA5, "R3 R4 single");
        run_ack(14'h3FFF, 3'b111, 8'hA5, "R3 all active");
        run_ack(14'h2001, 3'b011, 8'hC3, "R5 tx passthrough");
        run_ack(14'h1800, 3'b101, 8'h9E, "R5 rx passthrough");
        run_ack(14'h0FFF, 3'b000, 8'h77, "R5 modem passthrough");
        run_ack(14'h07FF, 3'b000, 8'h77, "R4 gpio with serial off");
        write_base(8'hFF);
        run_ack(14'h0001, 3'b111, 8'h00, "R4 lowest code");
        for (int n = 0; n < 300; n++) begin
            logic [13:0] r;
            r = 14'($urandom);
            if (($urandom % 6) == 0) r = 0;
            else if (($urandom % 3) == 0) r = r & 14'h07FF;
            if (($urandom % 10) == 0) write_base(8'($urandom));
            run_ack(r, 3'($urandom), 8'($urandom), "R3 R5 random");
        end
        do_reset();
        check("R1 read after second reset", {8'h0, reg_rdata}, 16'h000F);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule